// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block drives the bus during interrupt entry for a small 8-bit processor core. When a serviceable request arrives, it writes the register context to the stack as nine single-byte writes on consecutive cycles, with the address going down by one each cycle. It then reads a two-byte vector and hands the core a new program counter, a new stack pointer and an updated condition-code byte in one load cycle. The core supplies its register values, the current stack pointer and its condition codes on plain input ports. The sequencer supplies the bus address, write data, a read/write strobe and the load pulse.

Three request sources are arbitrated: a non-maskable-style request gated only by the X bit, an external line that is level- or edge-sensitive under a mode input, and an internal request that carries its own vector address. Two low-power entries are supported. A wait command stacks the context at once, so a later interrupt needs only the vector fetch. A stop command halts the bus until a wake-up arrives, then holds the bus quiet for a long or short recovery time. After recovery it either services the request or, for a masked X request, signals a plain resume.

Top module: `irq_entry_seq`

## Requirements
- R1: One cycle after a serviceable request is sampled in idle, nine write cycles (bus_rw=0) follow back to back at addresses SP, SP-1 … SP-8, carrying in turn PC low, PC high, IY low, IY high, IX low, IX high, B, A, CCR.
- R2: After the last stacking write, a read (bus_rw=1) at the vector address is followed by a read at vector+1. In the next cycle pc_load is high and pc_new holds {first byte, second byte}.
- R3: During pc_load, sp_new equals the sampled SP minus 9, and ccr_new equals the stacked CCR with bit 4 (I) set.
- R4: XIRQ wins over the external line, which wins over an internal request. Their vectors are 0xFFF4, 0xFFF2 and int_vec.
- R5: CCR bit 4 (I) = 1 blocks the external line and internal requests. CCR bit 6 (X) = 1 blocks XIRQ. A blocked request causes no bus cycle.
- R6: With irq_edge_mode=0 the external line is a level, and a line held high starts a new entry after each one completes. With irq_edge_mode=1, each rising edge yields exactly one entry, and an edge that arrives while busy is held until taken.
- R7: A one-cycle wait_cmd in idle performs the nine stacking writes and then leaves the bus quiet. A later serviceable request produces only the two vector reads and the load.
- R8: Reset taken while waiting discards the stacked state. The next request performs a full nine-write entry.
- R9: After stop_cmd, a wake-up sampled in stop is followed by exactly 4064 (stop_long_dly=1) or 4 (stop_long_dly=0) cycles with no bus activity before the next output event.
- R10: If the stop wake-up is XIRQ with X=1 and nothing else serviceable, the recovery ends with a one-cycle stop_resume and no bus cycle or load.
- R11: In and right after reset, bus_valid, pc_load and stop_resume are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 1 | External maskable request, active high |
| irq_edge_mode | input | 1 | 1 = rising-edge sensitive, 0 = level sensitive |
| xirq_line | input | 1 | Request gated by the X bit, active high |
| int_req | input | 1 | Internal peripheral request |
| int_vec | input | 16 | Vector address of the internal request |
| wait_cmd | input | 1 | Pulse: stack early and wait |
| stop_cmd | input | 1 | Pulse: enter stop |
| stop_long_dly | input | 1 | Stop recovery select: 1 long, 0 short |
| ccr_in | input | 8 | Current condition codes (bit 4 I, bit 6 X) |
| pc_in | input | 16 | Return program counter |
| iy_in | input | 16 | Index register Y |
| ix_in | input | 16 | Index register X |
| acc_a_in | input | 8 | Accumulator A |
| acc_b_in | input | 8 | Accumulator B |
| sp_in | input | 16 | Current stack pointer |
| rd_data | input | 8 | Read data from the bus |
| bus_valid | output | 1 | Bus cycle active |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| pc_load | output | 1 | One-cycle load of the new state |
| pc_new | output | 16 | New program counter |
| sp_new | output | 16 | New stack pointer |
| ccr_new | output | 8 | New condition codes |
| stop_resume | output | 1 | Pulse: leave stop without servicing |

## Verification
The hardest situations to reach are the ones that depend on when a request arrives relative to an entry already in progress. One case is an external edge that occurs in the middle of stacking another source. The other is a level request still held when the load completes. The stimulus raises XIRQ and the external line together, then drops the line only after the second entry has begun. In edge mode it pulses the line during the first entry's stacking writes. The stop recovery is measured by counting quiet cycles from the wake-up, with the X bit both clear and set.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned CTX_BYTES = 9;
  localparam int unsigned CCR_I_BIT = 4;
  localparam int unsigned CCR_X_BIT = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_LOAD,
    ST_WAIT, ST_STOP, ST_RECOV, ST_RESUME
  } seq_state_t;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] iy;
    logic [15:0] ix;
    logic [7:0]  b;
    logic [7:0]  a;
    logic [7:0]  ccr;
  } cpu_ctx_t;

  // Byte pushed at step k (R1 order).
  function automatic logic [7:0] ctx_byte(cpu_ctx_t c, logic [3:0] k);
    case (k)
      4'd0: return c.pc[7:0];
      4'd1: return c.pc[15:8];
      4'd2: return c.iy[7:0];
      4'd3: return c.iy[15:8];
      4'd4: return c.ix[7:0];
      4'd5: return c.ix[15:8];
      4'd6: return c.b;
      4'd7: return c.a;
      default: return c.ccr;
    endcase
  endfunction

  function automatic logic [15:0] stack_addr(logic [15:0] sp, logic [3:0] k);
    return sp - {12'd0, k};
  endfunction

  function automatic logic [15:0] sp_after(logic [15:0] sp);
    return sp - 16'(CTX_BYTES);
  endfunction

  function automatic logic [7:0] ccr_masked(logic [7:0] ccr);
    return ccr | (8'd1 << CCR_I_BIT);
  endfunction
endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb #(
  parameter logic [15:0] VEC_XIRQ = 16'hFFF4,
  parameter logic [15:0] VEC_IRQ  = 16'hFFF2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_line,
  input  logic        edge_mode,
  input  logic        xirq,
  input  logic        int_req,
  input  logic [15:0] int_vec,
  input  logic        i_mask,
  input  logic        x_mask,
  input  logic        take,
  output logic        svc_any,
  output logic        wake_any,
  output logic [15:0] svc_vec
);
  logic irq_prev, irq_pend;
  logic irq_rise, irq_act, svc_x, svc_i, svc_n, irq_taken;

  assign irq_rise  = irq_line & ~irq_prev;
  assign irq_act   = edge_mode ? (irq_pend | irq_rise) : irq_line;   // R6
  assign svc_x     = xirq & ~x_mask;                                // R5
  assign svc_i     = irq_act & ~i_mask;
  assign svc_n     = int_req & ~i_mask;
  assign svc_any   = svc_x | svc_i | svc_n;
  assign wake_any  = svc_any | xirq;
  assign irq_taken = take & ~svc_x & svc_i;

  always_comb begin                                                 // R4
    if (svc_x)      svc_vec = VEC_XIRQ;
    else if (svc_i) svc_vec = VEC_IRQ;
    else            svc_vec = int_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      irq_prev <= irq_line;
      irq_pend <= edge_mode & (irq_pend | irq_rise) & ~irq_taken;
    end
  end
endmodule

// File: rtl/irq_stop_timer.sv
module irq_stop_timer #(
  parameter int unsigned LONG_CYC  = 4064,
  parameter int unsigned SHORT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic expired
);
  localparam int unsigned CW = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;
  localparam logic [CW-1:0] LOAD_LONG  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] LOAD_SHORT = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          running;

  assign expired = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= long_sel ? LOAD_LONG : LOAD_SHORT;            // R9
    end else if (expired) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter logic [15:0] VEC_XIRQ  = 16'hFFF4,
  parameter logic [15:0] VEC_IRQ   = 16'hFFF2,
  parameter int unsigned STOP_LONG  = 4064,
  parameter int unsigned STOP_SHORT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_line,
  input  logic        irq_edge_mode,
  input  logic        xirq_line,
  input  logic        int_req,
  input  logic [15:0] int_vec,
  input  logic        wait_cmd,
  input  logic        stop_cmd,
  input  logic        stop_long_dly,
  input  logic [7:0]  ccr_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] iy_in,
  input  logic [15:0] ix_in,
  input  logic [7:0]  acc_a_in,
  input  logic [7:0]  acc_b_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  rd_data,
  output logic        bus_valid,
  output logic        bus_rw,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        pc_load,
  output logic [15:0] pc_new,
  output logic [15:0] sp_new,
  output logic [7:0]  ccr_new,
  output logic        stop_resume
);
  localparam logic [3:0] LAST_IDX = 4'(CTX_BYTES - 1);

  seq_state_t  state;
  logic [3:0]  idx;
  cpu_ctx_t    ctx;
  logic [15:0] sp_q, vec_q;
  logic [7:0]  vhi_q, vlo_q;
  logic        to_wait_q, svc_q;

  logic        svc_any, wake_any, expired, take, grab_ctx, timer_start;
  logic [15:0] svc_vec;

  // Named internal events (used by the checker)
  logic push_step, vec_hi_step, vec_lo_step, in_recov;
  assign push_step   = (state == ST_PUSH);
  assign vec_hi_step = (state == ST_VHI);
  assign vec_lo_step = (state == ST_VLO);
  assign in_recov    = (state == ST_RECOV);

  assign take = ((state == ST_IDLE || state == ST_WAIT) && svc_any) ||
                ((state == ST_STOP) && wake_any);
  assign grab_ctx = (state == ST_IDLE && (svc_any || wait_cmd)) ||
                    (state == ST_STOP && wake_any);
  assign timer_start = (state == ST_STOP) && wake_any;

  irq_req_arb #(.VEC_XIRQ(VEC_XIRQ), .VEC_IRQ(VEC_IRQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .edge_mode(irq_edge_mode),
    .xirq(xirq_line), .int_req(int_req), .int_vec(int_vec),
    .i_mask(ccr_in[CCR_I_BIT]), .x_mask(ccr_in[CCR_X_BIT]), .take(take),
    .svc_any(svc_any), .wake_any(wake_any), .svc_vec(svc_vec)
  );

  irq_stop_timer #(.LONG_CYC(STOP_LONG), .SHORT_CYC(STOP_SHORT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(timer_start), .long_sel(stop_long_dly),
    .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      ctx       <= '0;
      sp_q      <= '0;
      vec_q     <= '0;
      vhi_q     <= '0;
      vlo_q     <= '0;
      to_wait_q <= 1'b0;
      svc_q     <= 1'b0;
    end else begin
      if (grab_ctx) begin
        ctx  <= '{pc: pc_in, iy: iy_in, ix: ix_in, b: acc_b_in, a: acc_a_in, ccr: ccr_in};
        sp_q <= sp_in;
      end
      if (take) vec_q <= svc_vec;
      unique case (state)
        ST_IDLE: begin
          idx <= '0;
          if (svc_any) begin
            state <= ST_PUSH; to_wait_q <= 1'b0;                 // R1
          end else if (wait_cmd) begin
            state <= ST_PUSH; to_wait_q <= 1'b1;                 // R7
          end else if (stop_cmd) begin
            state <= ST_STOP;
          end
        end
        ST_PUSH: begin
          if (idx == LAST_IDX) begin
            idx   <= '0;
            state <= to_wait_q ? ST_WAIT : ST_VHI;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WAIT:  if (svc_any) state <= ST_VHI;
        ST_VHI:   begin vhi_q <= rd_data; state <= ST_VLO; end   // R2
        ST_VLO:   begin vlo_q <= rd_data; state <= ST_LOAD; end
        ST_LOAD:  state <= ST_IDLE;
        ST_STOP:  if (wake_any) begin svc_q <= svc_any; state <= ST_RECOV; end
        ST_RECOV: if (expired) begin                              // R10
          to_wait_q <= 1'b0;
          state     <= svc_q ? ST_PUSH : ST_RESUME;
        end
        ST_RESUME: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid   = push_step || vec_hi_step || vec_lo_step;
  assign bus_rw      = !push_step;
  assign bus_addr    = push_step   ? stack_addr(sp_q, idx) :
                       vec_hi_step ? vec_q :
                       vec_lo_step ? vec_q + 16'd1 : 16'd0;
  assign bus_wdata   = push_step ? ctx_byte(ctx, idx) : 8'd0;
  assign pc_load     = (state == ST_LOAD);
  assign pc_new      = {vhi_q, vlo_q};
  assign sp_new      = sp_after(sp_q);                            // R3
  assign ccr_new     = ccr_masked(ctx.ccr);
  assign stop_resume = (state == ST_RESUME);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_rw,
  input logic [15:0] bus_addr,
  input logic        pc_load,
  input logic [7:0]  ccr_new,
  input logic        stop_resume,
  input logic        push_step,
  input logic        vec_hi_step,
  input logic        vec_lo_step,
  input logic        in_recov
);
  a_r1_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (push_step && $past(push_step)) |-> (bus_addr == $past(bus_addr) - 16'd1));

  a_r2_vector_pair: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hi_step |=> (bus_valid && bus_rw && bus_addr == $past(bus_addr) + 16'd1));

  a_r2_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vec_lo_step |=> pc_load);

  a_r3_ibit_set: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ccr_new[4]);

  a_r9_recovery_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_recov |-> (!bus_valid && !pc_load && !stop_resume));

  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_valid, pc_load, stop_resume}));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rw(bus_rw),
  .bus_addr(bus_addr), .pc_load(pc_load), .ccr_new(ccr_new),
  .stop_resume(stop_resume), .push_step(push_step), .vec_hi_step(vec_hi_step),
  .vec_lo_step(vec_lo_step), .in_recov(in_recov)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_line = 0, irq_edge_mode = 0, xirq_line = 0, int_req = 0;
  logic [15:0] int_vec = 16'hFFD6;
  logic wait_cmd = 0, stop_cmd = 0, stop_long_dly = 0;
  logic [7:0]  ccr_in = 8'h00;
  logic [15:0] pc_in = 16'hC123, iy_in = 16'h4455, ix_in = 16'h6677, sp_in = 16'h01FF;
  logic [7:0]  acc_a_in = 8'hAA, acc_b_in = 8'hBB;
  logic [7:0]  rd_data;
  logic        bus_valid, bus_rw, pc_load, stop_resume;
  logic [15:0] bus_addr, pc_new, sp_new;
  logic [7:0]  bus_wdata, ccr_new;

  int checks = 0, fails = 0, events = 0, cyc = 0;
  int qk[$];
  logic [15:0] qa[$], qd[$];
  logic [7:0]  qc[$];
  string       qt[$];

  always #4ns clk = ~clk;

  assign rd_data = bus_addr[7:0] ^ 8'h5A;   // modelled vector memory

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_edge_mode(irq_edge_mode),
    .xirq_line(xirq_line), .int_req(int_req), .int_vec(int_vec),
    .wait_cmd(wait_cmd), .stop_cmd(stop_cmd), .stop_long_dly(stop_long_dly),
    .ccr_in(ccr_in), .pc_in(pc_in), .iy_in(iy_in), .ix_in(ix_in),
    .acc_a_in(acc_a_in), .acc_b_in(acc_b_in), .sp_in(sp_in), .rd_data(rd_data),
    .bus_valid(bus_valid), .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pc_load(pc_load), .pc_new(pc_new), .sp_new(sp_new), .ccr_new(ccr_new),
    .stop_resume(stop_resume)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int k, input logic [15:0] a, input logic [15:0] d,
                          input logic [7:0] c, input string t);
    qk.push_back(k); qa.push_back(a); qd.push_back(d); qc.push_back(c); qt.push_back(t);
  endtask

  // Driver side: expected bus items of one entry
  task automatic exp_entry(input bit full, input logic [15:0] vec, input string tag);
    logic [7:0] by [9];
    by[0] = pc_in[7:0]; by[1] = pc_in[15:8]; by[2] = iy_in[7:0]; by[3] = iy_in[15:8];
    by[4] = ix_in[7:0]; by[5] = ix_in[15:8]; by[6] = acc_b_in; by[7] = acc_a_in; by[8] = ccr_in;
    if (full) for (int k = 0; k < 9; k++) push_exp(0, sp_in - 16'(k), {8'h00, by[k]}, 8'h00, "R1");
    push_exp(1, vec, 16'h0, 8'h00, tag);
    push_exp(1, vec + 16'd1, 16'h0, 8'h00, "R2");
    push_exp(2, {vec[7:0] ^ 8'h5A, 8'((vec + 16'd1) & 16'hFF) ^ 8'h5A},
             sp_in - 16'd9, ccr_in | 8'h10, "R3");
  endtask

  // Monitor: pop and compare each output event
  always @(negedge clk) begin
    if (rst_n && (bus_valid || pc_load || stop_resume)) begin
      int k;
      events++;
      k = bus_valid ? (bus_rw ? 1 : 0) : (pc_load ? 2 : 3);
      if (qk.size() == 0) begin
        check(1'b0, "R5 unexpected event", 32'(k), 32'hFFFF);
      end else begin
        int ek; logic [15:0] ea, ed; logic [7:0] ec; string et;
        ek = qk.pop_front(); ea = qa.pop_front(); ed = qd.pop_front();
        ec = qc.pop_front(); et = qt.pop_front();
        check(k == ek, et, 32'(k), 32'(ek));
        if (k == ek) begin
          if (k == 0) check(bus_addr == ea && bus_wdata == ed[7:0], et,
                            {bus_addr, 8'h0, bus_wdata}, {ea, 8'h0, ed[7:0]});
          if (k == 1) check(bus_addr == ea, et, 32'(bus_addr), 32'(ea));
          if (k == 2) check(pc_new == ea && sp_new == ed && ccr_new == ec, et,
                            {pc_new, sp_new}, {ea, ed});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic drain(input string tag);
    int n = 0;
    while (qk.size() != 0 && n < 400) begin @(negedge clk); n++; end
    check(qk.size() == 0, tag, 32'(qk.size()), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int e0 = events;
    repeat (n) @(negedge clk);
    check(events == e0, tag, 32'(events - e0), 0);
  endtask

  task automatic stop_run(input bit long_sel, input int exp_n, input string tag);
    int n = 0;
    stop_long_dly = long_sel;
    @(negedge clk); stop_cmd = 1;
    @(negedge clk); stop_cmd = 0; xirq_line = 1;
    @(negedge clk); xirq_line = 0;
    while (!bus_valid && !stop_resume && n < 6000) begin n++; @(negedge clk); end
    check(n == exp_n, tag, 32'(n), 32'(exp_n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_valid && !pc_load && !stop_resume, "R11 in reset",
          {bus_valid, pc_load, stop_resume}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!bus_valid && !pc_load && !stop_resume, "R11 after reset",
          {bus_valid, pc_load, stop_resume}, 0);

    // R1/R2/R3: level IRQ, first write in the next cycle
    exp_entry(1, 16'hFFF2, "R2");
    irq_line = 1;
    @(negedge clk); irq_line = 0;
    check(bus_valid && !bus_rw && bus_addr == sp_in, "R1 first write timing",
          {bus_valid, bus_rw, bus_addr}, {2'b10, sp_in});
    drain("R1");

    // R4 + R6 level: XIRQ first, held IRQ re-enters
    pc_in = 16'h8001; sp_in = 16'h00F0;
    exp_entry(1, 16'hFFF4, "R4");
    exp_entry(1, 16'hFFF2, "R6");
    xirq_line = 1; irq_line = 1;
    @(negedge clk); xirq_line = 0;
    while (!pc_load) @(negedge clk);
    @(negedge clk); @(negedge clk); irq_line = 0;
    drain("R6");

    // R4: IRQ beats internal; internal vector alone
    exp_entry(1, 16'hFFF2, "R4");
    irq_line = 1; int_req = 1;
    @(negedge clk); irq_line = 0; int_req = 0;
    drain("R4");
    exp_entry(1, 16'hFFD6, "R4");
    int_req = 1;
    @(negedge clk); int_req = 0;
    drain("R4");

    // R5: masks
    ccr_in = 8'h50; irq_line = 1; int_req = 1; xirq_line = 1;
    quiet(8, "R5");
    irq_line = 0; int_req = 0; xirq_line = 0;
    @(negedge clk); ccr_in = 8'h10;
    exp_entry(1, 16'hFFF4, "R5");
    xirq_line = 1;
    @(negedge clk); xirq_line = 0;
    drain("R5");
    ccr_in = 8'h00;

    // R6: edge mode, edge during busy held; held line gives one entry
    irq_edge_mode = 1;
    @(negedge clk);
    exp_entry(1, 16'hFFF4, "R6");
    exp_entry(1, 16'hFFF2, "R6");
    xirq_line = 1;
    @(negedge clk); xirq_line = 0;
    @(negedge clk); irq_line = 1;
    @(negedge clk); irq_line = 0;
    drain("R6");
    exp_entry(1, 16'hFFF2, "R6");
    irq_line = 1;
    drain("R6");
    quiet(10, "R6");
    irq_line = 0; irq_edge_mode = 0;
    @(negedge clk);

    // R7: wait mode
    sp_in = 16'h0180; pc_in = 16'h9A9B;
    exp_entry(1, 16'hFFF2, "R7");
    repeat (3) begin qk.pop_back(); qa.pop_back(); qd.pop_back(); qc.pop_back(); qt.pop_back(); end
    wait_cmd = 1;
    @(negedge clk); wait_cmd = 0;
    drain("R7");
    quiet(6, "R7");
    exp_entry(0, 16'hFFF2, "R7");
    irq_line = 1;
    @(negedge clk); irq_line = 0;
    drain("R7");

    // R8: reset ends wait
    exp_entry(1, 16'hFFF2, "R8");
    repeat (3) begin qk.pop_back(); qa.pop_back(); qd.pop_back(); qc.pop_back(); qt.pop_back(); end
    wait_cmd = 1;
    @(negedge clk); wait_cmd = 0;
    drain("R8");
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    quiet(3, "R8");
    exp_entry(1, 16'hFFF2, "R8");
    irq_line = 1;
    @(negedge clk); irq_line = 0;
    drain("R8");

    // R9: short stop recovery with service
    exp_entry(1, 16'hFFF4, "R9");
    stop_run(1'b0, 4, "R9 short recovery");
    drain("R9");

    // R9/R10: long recovery, masked XIRQ resumes
    ccr_in = 8'h40;
    push_exp(3, 16'h0, 16'h0, 8'h00, "R10");
    stop_run(1'b1, 4064, "R9 long recovery");
    drain("R10");
    quiet(5, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule